// File: doc/BRIEF.md
# I/O Window Chip-Select Decoder

This block watches the command strobes and the 16-bit address of an I/O bus. It decides which of five peripheral selects an access falls into. A five-bit jumper value places a 32-byte-aligned base inside the first kilobyte of I/O space. A three-bit layout code then chooses how the region above that base is divided among four active-low external chip selects and one active-low select for an on-board digital I/O register block. Some layouts give overlapping windows. Each overlapping select is decoded independently, so more than one select can be low in the same cycle.

The block also drives the direction of the external bidirectional data buffer. The direction goes high, toward the host, only while a read hits a window that the current layout enables. It stays low for writes, idle cycles and misses. All outputs are registered on the block clock, so each output follows its inputs by one clock edge.

Top module: `io_window_decoder`

## Requirements
- R1: While rst_ni is low, every select output (cs_no[3:0], dio_cs_no) is 1 and data_dir_o is 0, whatever the bus inputs.
- R2: The outputs are registered. They reflect the inputs sampled at the previous rising clock edge. No select is low unless that sample showed an I/O cycle: aen_i low and exactly one of ior_ni, iow_ni low.
- R3: An access can hit only if addr_i[15:10] is zero and addr_i is at least base_sel_i*32. The offset is addr_i minus base_sel_i*32, and windows are given as offset ranges.
- R4: Layout codes 3'b000, 3'b100 and 3'b110 keep every select inactive and data_dir_o at 0.
- R5: Layout 3'b001 asserts only dio_cs_no, for offsets 0..3. cs_no stays all ones.
- R6: Layout 3'b010 asserts cs_no[0] for offsets 0..15, and all other selects stay inactive. Layout 3'b011 does the same and also asserts dio_cs_no for offsets 0..3.
- R7: Layout 3'b101 asserts cs_no[0], cs_no[1], cs_no[2] and cs_no[3] for single offsets 4, 5, 6 and 7 respectively, and dio_cs_no for offsets 0..3.
- R8: Layout 3'b111 asserts cs_no[0..3] for offsets 0..7, 8..15, 16..23 and 24..31, and dio_cs_no for offsets 32..35. The last of these windows reaches into the next 32-byte block above the base.
- R9: data_dir_o is 1 only when the sampled cycle is a read (ior_ni low, iow_ni high, aen_i low) and at least one select is asserted. Otherwise it is 0.
- R10: Overlapping windows are decoded independently. Under layout 3'b011, offsets 0..3 assert cs_no[0] and dio_cs_no together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 16 | I/O address |
| aen_i | input | 1 | Address enable. High marks a non-I/O (DMA) cycle |
| ior_ni | input | 1 | Active-low I/O read strobe |
| iow_ni | input | 1 | Active-low I/O write strobe |
| base_sel_i | input | 5 | Jumper base, placed at address bits 9..5 |
| layout_i | input | 3 | Window layout code |
| cs_no | output | 4 | Active-low external chip selects |
| dio_cs_no | output | 1 | Active-low digital I/O block select |
| data_dir_o | output | 1 | Data buffer direction. 1 drives toward the host |

## Verification
Every layout code is swept with reads across offsets 0 to 40 from a mid-range base. This exposes each window edge, the single-byte selects and the region beyond 32 that only one layout reaches. Writes over the same addresses separate the select decoding from the direction output. Cycles with aen_i high, with both strobes low and with no strobe separate cycle qualification from address matching. Addresses below the base, addresses with upper bits set, and the topmost base with its 32..35 window wrapping past 1 KB check the base arithmetic and borrow handling.

// File: rtl/iocs_pkg.sv
package iocs_pkg;
  localparam int unsigned NUM_CS  = 4;
  localparam int unsigned NUM_SEL = NUM_CS + 1;  // index NUM_CS is the DIO select
  localparam int unsigned OFS_W   = 6;

  typedef enum logic [2:0] {
    LAYOUT_OFF      = 3'b000,
    LAYOUT_DIO      = 3'b001,
    LAYOUT_WIDE     = 3'b010,
    LAYOUT_WIDE_DIO = 3'b011,
    LAYOUT_RSVD4    = 3'b100,
    LAYOUT_BYTES    = 3'b101,
    LAYOUT_RSVD6    = 3'b110,
    LAYOUT_SPLIT    = 3'b111
  } layout_e;

  typedef struct packed {
    logic             en;
    logic [OFS_W-1:0] lo;
    logic [OFS_W-1:0] hi;
  } window_t;

  function automatic window_t mk_win(int unsigned lo, int unsigned hi);
    window_t w;
    w.en = 1'b1;
    w.lo = OFS_W'(lo);
    w.hi = OFS_W'(hi);
    return w;
  endfunction

  function automatic window_t window_of(layout_e layout, int unsigned sel);
    window_t w;
    w = '0;
    unique case (layout)
      LAYOUT_DIO:      if (sel == NUM_CS) w = mk_win(0, 3);
      LAYOUT_WIDE:     if (sel == 0) w = mk_win(0, 15);
      LAYOUT_WIDE_DIO: begin
        if (sel == 0)      w = mk_win(0, 15);
        if (sel == NUM_CS) w = mk_win(0, 3);
      end
      LAYOUT_BYTES: begin
        if (sel < NUM_CS) w = mk_win(4 + sel, 4 + sel);
        else              w = mk_win(0, 3);
      end
      LAYOUT_SPLIT: begin
        if (sel < NUM_CS) w = mk_win(8 * sel, 8 * sel + 7);
        else              w = mk_win(32, 35);
      end
      default: w = '0;
    endcase
    return w;
  endfunction
endpackage

// File: rtl/iocs_cycle_qual.sv
module iocs_cycle_qual (
  input  logic aen_i,
  input  logic ior_ni,
  input  logic iow_ni,
  output logic io_cyc_o,
  output logic rd_cyc_o
);
  // exactly one strobe active and no DMA cycle
  assign io_cyc_o = ~aen_i & (ior_ni ^ iow_ni);
  assign rd_cyc_o = io_cyc_o & ~ior_ni;
endmodule

// File: rtl/iocs_base_offset.sv
module iocs_base_offset #(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned BASE_LSB = 5,
  parameter int unsigned BASE_W   = 5,
  parameter int unsigned OFS_W    = 6
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BASE_W-1:0] base_i,
  output logic              in_range_o,
  output logic [OFS_W-1:0]  offset_o
);
  localparam int unsigned LOW_W = BASE_LSB + BASE_W;

  logic [LOW_W:0] base_full;
  logic [LOW_W:0] diff;
  logic           upper_zero;
  logic           borrow;
  logic           far;

  assign base_full  = {1'b0, base_i, {BASE_LSB{1'b0}}};
  assign diff       = {1'b0, addr_i[LOW_W-1:0]} - base_full;
  assign upper_zero = (addr_i[ADDR_W-1:LOW_W] == '0);
  assign borrow     = diff[LOW_W];
  assign far        = |diff[LOW_W-1:OFS_W];
  assign in_range_o = upper_zero & ~borrow & ~far;
  assign offset_o   = diff[OFS_W-1:0];
endmodule

// File: rtl/iocs_window_hit.sv
module iocs_window_hit #(
  parameter int unsigned OFS_W = 6
) (
  input  logic             en_i,
  input  logic [OFS_W-1:0] lo_i,
  input  logic [OFS_W-1:0] hi_i,
  input  logic [OFS_W-1:0] offset_i,
  input  logic             in_range_i,
  output logic             hit_o
);
  assign hit_o = en_i & in_range_i & (offset_i >= lo_i) & (offset_i <= hi_i);
endmodule

// File: rtl/io_window_decoder.sv
module io_window_decoder
  import iocs_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned BASE_LSB = 5,
  parameter int unsigned BASE_W   = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              aen_i,
  input  logic              ior_ni,
  input  logic              iow_ni,
  input  logic [BASE_W-1:0] base_sel_i,
  input  logic [2:0]        layout_i,
  output logic [NUM_CS-1:0] cs_no,
  output logic              dio_cs_no,
  output logic              data_dir_o
);
  logic               io_cyc, rd_cyc;
  logic               in_range;
  logic [OFS_W-1:0]   offset;
  logic [NUM_SEL-1:0] hit;
  layout_e            layout;

  assign layout = layout_e'(layout_i);

  iocs_cycle_qual u_qual (
    .aen_i    (aen_i),
    .ior_ni   (ior_ni),
    .iow_ni   (iow_ni),
    .io_cyc_o (io_cyc),
    .rd_cyc_o (rd_cyc)
  );

  iocs_base_offset #(
    .ADDR_W  (ADDR_W),
    .BASE_LSB(BASE_LSB),
    .BASE_W  (BASE_W),
    .OFS_W   (OFS_W)
  ) u_ofs (
    .addr_i    (addr_i),
    .base_i    (base_sel_i),
    .in_range_o(in_range),
    .offset_o  (offset)
  );

  for (genvar s = 0; s < NUM_SEL; s++) begin : g_sel
    window_t win;
    assign win = window_of(layout, s);
    iocs_window_hit #(.OFS_W(OFS_W)) u_hit (
      .en_i      (win.en),
      .lo_i      (win.lo),
      .hi_i      (win.hi),
      .offset_i  (offset),
      .in_range_i(in_range),
      .hit_o     (hit[s])
    );
  end

  logic [NUM_SEL-1:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q      <= '0;
      data_dir_o <= 1'b0;
    end else begin
      sel_q      <= io_cyc ? hit : '0;
      data_dir_o <= rd_cyc & (|hit);
    end
  end

  assign cs_no     = ~sel_q[NUM_CS-1:0];
  assign dio_cs_no = ~sel_q[NUM_CS];
endmodule

// File: rtl/io_window_decoder_chk.sv
module io_window_decoder_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] addr_i,
  input logic        aen_i,
  input logic        ior_ni,
  input logic        iow_ni,
  input logic [2:0]  layout_i,
  input logic [3:0]  cs_no,
  input logic        dio_cs_no,
  input logic        data_dir_o
);
  logic io_seen, rd_seen, any_sel;
  assign io_seen = ~aen_i & (ior_ni != iow_ni);
  assign rd_seen = io_seen & ~ior_ni;
  assign any_sel = (cs_no != 4'hF) | ~dio_cs_no;

  AST_NO_CYCLE_NO_SELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_seen |=> (cs_no == 4'hF && dio_cs_no && !data_dir_o)); // R2
  AST_UPPER_ADDR_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[15:10] != 6'd0) |=> (cs_no == 4'hF && dio_cs_no)); // R3
  AST_DISABLED_LAYOUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (layout_i == 3'b000 || layout_i == 3'b100 || layout_i == 3'b110)
      |=> (cs_no == 4'hF && dio_cs_no && !data_dir_o)); // R4
  AST_DIO_ONLY_LAYOUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (layout_i == 3'b001) |=> (cs_no == 4'hF)); // R5
  AST_WIDE_LAYOUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (layout_i == 3'b010) |=> (cs_no[3:1] == 3'b111 && dio_cs_no)); // R6
  AST_DIR_READ_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_dir_o == ($past(rd_seen) && any_sel)); // R9
endmodule

bind io_window_decoder io_window_decoder_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .aen_i     (aen_i),
  .ior_ni    (ior_ni),
  .iow_ni    (iow_ni),
  .layout_i  (layout_i),
  .cs_no     (cs_no),
  .dio_cs_no (dio_cs_no),
  .data_dir_o(data_dir_o)
);

// File: tb/io_window_decoder_test.sv
module io_window_decoder_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr = 16'h0300;
  logic        aen = 1'b0;
  logic        ior_n = 1'b0;
  logic        iow_n = 1'b1;
  logic [4:0]  base = 5'd24;
  logic [2:0]  layout = 3'b111;
  logic [3:0]  cs_n;
  logic        dio_n;
  logic        dir;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [5:0] exp;  // {dir, dio_n, cs_n[3:0]}
    string      tag;
  } item_t;
  item_t sb[$];

  always #2 clk = ~clk;

  io_window_decoder uut (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .addr_i    (addr),
    .aen_i     (aen),
    .ior_ni    (ior_n),
    .iow_ni    (iow_n),
    .base_sel_i(base),
    .layout_i  (layout),
    .cs_no     (cs_n),
    .dio_cs_no (dio_n),
    .data_dir_o(dir)
  );

  function automatic logic in_w(int o, int lo, int hi);
    return (o >= lo) && (o <= hi);
  endfunction

  // reference model straight from the requirements
  function automatic logic [5:0] model(logic [15:0] a, logic [4:0] b, logic [2:0] lay,
                                       logic ae, logic rn, logic wn);
    logic [3:0] cs = 4'b0000;
    logic       dio = 1'b0;
    logic       io, rd;
    int         o;
    io = !ae && (rn != wn);
    rd = io && !rn;
    o  = int'(a) - int'(b) * 32;
    if (io && a[15:10] == 6'd0 && o >= 0) begin
      case (lay)
        3'b001: dio = in_w(o, 0, 3);
        3'b010: cs[0] = in_w(o, 0, 15);
        3'b011: begin cs[0] = in_w(o, 0, 15); dio = in_w(o, 0, 3); end
        3'b101: begin
          for (int k = 0; k < 4; k++) cs[k] = (o == 4 + k);
          dio = in_w(o, 0, 3);
        end
        3'b111: begin
          for (int k = 0; k < 4; k++) cs[k] = in_w(o, 8 * k, 8 * k + 7);
          dio = in_w(o, 32, 35);
        end
        default: ;
      endcase
    end
    return {rd && (|cs || dio), ~dio, ~cs};
  endfunction

  task automatic drive(logic [15:0] a, logic [4:0] b, logic [2:0] lay,
                       logic ae, logic rn, logic wn, string tag);
    item_t it;
    @(negedge clk);
    addr = a; base = b; layout = lay; aen = ae; ior_n = rn; iow_n = wn;
    it.exp = model(a, b, lay, ae, rn, wn);
    it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        n_cmp++;
        if ({dir, dio_n, cs_n} !== it.exp) begin
          n_bad++;
          $display("FAIL %s addr=%h layout=%b actual=%b expected=%b",
                   it.tag, addr, layout, {dir, dio_n, cs_n}, it.exp);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  string tg;

  initial begin
    // R1: reset holds outputs idle while a hitting read is presented
    #9;
    n_cmp++;
    if ({dir, dio_n, cs_n} !== 6'b011111) begin
      n_bad++;
      $display("FAIL R1 actual=%b expected=%b", {dir, dio_n, cs_n}, 6'b011111);
    end
    @(negedge clk);
    rst_ni = 1'b1;

    // sweep every layout with reads, then writes
    for (int lay = 0; lay < 8; lay++) begin
      case (lay)
        0, 4, 6: tg = "R4";
        1: tg = "R5";
        2: tg = "R6";
        3: tg = "R10";
        5: tg = "R7";
        default: tg = "R8";
      endcase
      for (int o = 0; o <= 40; o++)
        drive(16'h0300 + 16'(o), 5'd24, 3'(lay), 1'b0, 1'b0, 1'b1, {tg, "/R9 read"});
      for (int o = 0; o <= 40; o += 3)
        drive(16'h0300 + 16'(o), 5'd24, 3'(lay), 1'b0, 1'b1, 1'b0, {tg, "/R9 write"});
    end

    // R2: cycle qualification
    for (int o = 0; o < 8; o++) begin
      drive(16'h0300 + 16'(o), 5'd24, 3'b111, 1'b1, 1'b0, 1'b1, "R2 aen high");
      drive(16'h0300 + 16'(o), 5'd24, 3'b101, 1'b0, 1'b0, 1'b0, "R2 both strobes");
      drive(16'h0300 + 16'(o), 5'd24, 3'b011, 1'b0, 1'b1, 1'b1, "R2 no strobe");
    end

    // R3: base arithmetic
    drive(16'h02FF, 5'd24, 3'b111, 1'b0, 1'b0, 1'b1, "R3 below base");
    drive(16'h02E0, 5'd24, 3'b111, 1'b0, 1'b0, 1'b1, "R3 below base block");
    drive(16'h0700, 5'd24, 3'b111, 1'b0, 1'b0, 1'b1, "R3 upper bit 10");
    drive(16'h8300, 5'd24, 3'b011, 1'b0, 1'b0, 1'b1, "R3 upper bit 15");
    drive(16'h0000, 5'd0,  3'b111, 1'b0, 1'b0, 1'b1, "R3 base zero");
    drive(16'h0023, 5'd0,  3'b111, 1'b0, 1'b0, 1'b1, "R3/R8 base zero dio top");
    drive(16'h03E0, 5'd31, 3'b111, 1'b0, 1'b0, 1'b1, "R3 top base");
    drive(16'h03FF, 5'd31, 3'b111, 1'b0, 1'b0, 1'b1, "R3 top base last");
    drive(16'h0400, 5'd31, 3'b111, 1'b0, 1'b0, 1'b1, "R3/R8 dio wraps past 1K");
    drive(16'h0140, 5'd9,  3'b111, 1'b0, 1'b0, 1'b1, "R8 dio odd base");
    drive(16'h0144, 5'd9,  3'b111, 1'b0, 1'b0, 1'b1, "R8 past dio");
    drive(16'h0102, 5'd8,  3'b011, 1'b0, 1'b1, 1'b0, "R10 overlap write");
    drive(16'h0102, 5'd8,  3'b011, 1'b0, 1'b0, 1'b1, "R10 overlap read");
    drive(16'h0105, 5'd8,  3'b101, 1'b0, 1'b0, 1'b1, "R7 byte cs1");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule